// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is a free-running 8-bit up-counter that restarts whenever its count reaches a programmable period value. Each restart produces a one-cycle match pulse on `match_o`, which other peripherals may use directly, for example as a PWM time base or as an SPI shift clock. The counter advances on prescaled ticks: every clock cycle, every fourth cycle or every sixteenth cycle.

The same match pulse also drives a 4-bit postscaler. The postscaler groups between 1 and 16 consecutive matches. When a group completes, it sets an interrupt flag. The flag stays set until software clears it. The interrupt output is the flag gated by a separate enable input.

Software programs the block through three write strobes: control, period and count. The control byte holds the postscale ratio, the run bit and the prescale select. The register bus decode that produces these strobes lives outside this block.

Top module: `pmt_timer`

## Requirements
- R1: After reset, `count_o` is 0, `match_o` is 0, `flag_o` is 0 and `irq_o` is 0, whatever `irq_en_i` is. The period register resets to 255, and the control register resets to 0, which means stopped.
- R2: The control byte sets the run bit in bit 2. While the run bit is 1, the count rises by one on each prescaled tick. While it is 0, the count holds its value.
- R3: On a tick where the count equals the period value P, the count returns to 0, so one full period is P+1 ticks. `match_o` is high for exactly the cycle in which the count shows that 0. With P=0, the count stays at 0 and one match occurs per tick.
- R4: Control bits 1:0 select the prescale ratio. 00 gives one tick per clock, 01 gives one tick every 4 clocks, and 10 or 11 give one tick every 16 clocks.
- R5: Control bits 6:3 hold a value N. The flag sets after N+1 counted match pulses, with N=0 meaning 1:1 and N=15 meaning 1:16. `flag_o` rises in the cycle after the `match_o` pulse that completes the group.
- R6: Once set, `flag_o` stays high until `flag_clr_i` is pulsed. The flag is 0 in the cycle after that pulse, provided no set occurs at the same time.
- R7: When a flag set and `flag_clr_i` fall in the same cycle, the set wins and `flag_o` stays 1.
- R8: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high, in the same cycle.
- R9: Writing the control register or the period register clears the postscaler's match count. A match pulse present in the cycle of such a write is not counted. The count itself does not change.
- R10: A count write loads `cnt_wdata_i` at the next edge and takes priority over a tick. It also clears the prescaler and the postscaler, so the next tick arrives one full prescale ratio after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_wdata_i | input | 7 | Control data: [6:3] postscale, [2] run, [1:0] prescale |
| per_wr_i | input | 1 | Write strobe for the period register |
| per_wdata_i | input | 8 | Period value |
| cnt_wr_i | input | 1 | Write strobe for the count |
| cnt_wdata_i | input | 8 | Value loaded into the count |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | 8 | Current count |
| match_o | output | 1 | Unscaled one-cycle match pulse |
| flag_o | output | 1 | Latched interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit count, a 4-bit postscaler, and prescale exponents of 2 and 4. With these values the widest cases fit in a few dozen cycles. A 1:16 prescale and a full 1:16 postscale group both finish quickly when the period is small.

Short periods of 0, 1 and 3 make the wrap, the per-tick match and the postscaler grouping visible cycle by cycle. A period of 9 leaves room to load the count mid-run and watch the prescaler restart.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;

    // Prescale ratio selection carried in the low control bits
    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV4   = 2'b01,
        PRE_DIV16A = 2'b10,
        PRE_DIV16B = 2'b11
    } pre_sel_e;

    localparam int unsigned PRE_SEL_W = 2;

endpackage

// File: rtl/pmt_prescaler.sv
`timescale 1ns/1ps
module pmt_prescaler
    import pmt_pkg::*;
#(
    parameter int unsigned PRE_MID_LOG2 = 2,
    parameter int unsigned PRE_MAX_LOG2 = 4
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  pre_sel_e sel_i,
    input  logic     clear_i,
    output logic     tick_o
);

    localparam int unsigned PRE_W = (PRE_MAX_LOG2 > 0) ? PRE_MAX_LOG2 : 1;

    generate
        if (PRE_MAX_LOG2 == 0) begin : g_bypass
            logic unused_in;
            assign unused_in = clear_i ^ sel_i[0] ^ sel_i[1] ^ clk_i ^ rst_ni;
            assign tick_o    = run_i;
        end else begin : g_div
            localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << PRE_MID_LOG2) - 1);
            localparam logic [PRE_W-1:0] LIM_MAX = PRE_W'((1 << PRE_MAX_LOG2) - 1);

            typedef struct packed {
                logic [PRE_W-1:0] cnt;
            } pre_state_t;

            pre_state_t       st_d, st_q;
            logic [PRE_W-1:0] limit;
            logic             tick;

            always_comb begin
                unique case (sel_i)
                    PRE_DIV1: limit = '0;
                    PRE_DIV4: limit = LIM_MID;
                    default:  limit = LIM_MAX;
                endcase
            end

            always_comb begin
                st_d = st_q;
                tick = run_i && (st_q.cnt >= limit);
                if (clear_i) begin
                    st_d.cnt = '0;
                end else if (tick) begin
                    st_d.cnt = '0;
                end else if (run_i) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick_o = tick;

            // R10
            pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                clear_i |=> (st_q.cnt == '0));

            // R4
            pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (run_i && !clear_i && (sel_i == PRE_DIV1)) |=> (st_q.cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/pmt_counter.sv
`timescale 1ns/1ps
module pmt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             match;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            if (st_q.cnt == period_i) begin
                st_d.cnt   = '0;
                st_d.match = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign match_o = st_q.match;

    // R3
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> (count_o == '0));

    // R10
    load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (count_o == $past(wdata_i)));

    // R2
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_i) |=> ($stable(count_o) && !match_o));

endmodule

// File: rtl/pmt_postscaler.sv
`timescale 1ns/1ps
module pmt_postscaler #(
    parameter int unsigned PS_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            match_i,
    input  logic            clear_i,
    input  logic [PS_W-1:0] sel_i,
    input  logic            flag_clr_i,
    output logic            flag_o
);

    typedef struct packed {
        logic [PS_W-1:0] pcnt;
        logic            flag;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic      group_done;
    logic      set_flag;

    always_comb begin
        st_d       = st_q;
        group_done = (st_q.pcnt >= sel_i);
        set_flag   = match_i && !clear_i && group_done;
        if (clear_i) begin
            st_d.pcnt = '0;
        end else if (match_i) begin
            st_d.pcnt = group_done ? '0 : st_q.pcnt + 1'b1;
        end
        st_d.flag = set_flag | (st_q.flag & ~flag_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R9
    post_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (st_q.pcnt == '0));

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R6
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !match_i) |=> !flag_o);

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && match_i && !clear_i && (st_q.pcnt >= sel_i)) |=> flag_o);

endmodule

// File: rtl/pmt_timer.sv
`timescale 1ns/1ps
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned PS_W         = 4,
    parameter int unsigned PRE_MID_LOG2 = 2,
    parameter int unsigned PRE_MAX_LOG2 = 4,
    parameter int unsigned RUN_BIT      = 2,
    parameter int unsigned PS_LSB       = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       ctl_wr_i,
    input  logic [PS_LSB+PS_W-1:0]     ctl_wdata_i,
    input  logic                       per_wr_i,
    input  logic [CNT_W-1:0]           per_wdata_i,
    input  logic                       cnt_wr_i,
    input  logic [CNT_W-1:0]           cnt_wdata_i,
    input  logic                       flag_clr_i,
    input  logic                       irq_en_i,
    output logic [CNT_W-1:0]           count_o,
    output logic                       match_o,
    output logic                       flag_o,
    output logic                       irq_o
);

    localparam int unsigned CTL_W = PS_LSB + PS_W;

    typedef struct packed {
        logic [PS_W-1:0]  post_sel;
        logic             run;
        pre_sel_e         pre_sel;
        logic [CNT_W-1:0] period;
    } reg_state_t;

    reg_state_t rg_d, rg_q;
    logic       tick;
    logic       post_clear;
    logic       match;
    logic       flag;

    always_comb begin
        rg_d = rg_q;
        if (ctl_wr_i) begin
            rg_d.post_sel = ctl_wdata_i[CTL_W-1:PS_LSB];
            rg_d.run      = ctl_wdata_i[RUN_BIT];
            rg_d.pre_sel  = pre_sel_e'(ctl_wdata_i[PRE_SEL_W-1:0]);
        end
        if (per_wr_i) begin
            rg_d.period = per_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q.post_sel <= '0;
            rg_q.run      <= 1'b0;
            rg_q.pre_sel  <= PRE_DIV1;
            rg_q.period   <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign post_clear = ctl_wr_i | per_wr_i | cnt_wr_i;

    pmt_prescaler #(
        .PRE_MID_LOG2 (PRE_MID_LOG2),
        .PRE_MAX_LOG2 (PRE_MAX_LOG2)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (rg_q.run),
        .sel_i   (rg_q.pre_sel),
        .clear_i (cnt_wr_i),
        .tick_o  (tick)
    );

    pmt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .wr_i     (cnt_wr_i),
        .wdata_i  (cnt_wdata_i),
        .period_i (rg_q.period),
        .count_o  (count_o),
        .match_o  (match)
    );

    pmt_postscaler #(
        .PS_W (PS_W)
    ) u_post (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .match_i    (match),
        .clear_i    (post_clear),
        .sel_i      (rg_q.post_sel),
        .flag_clr_i (flag_clr_i),
        .flag_o     (flag)
    );

    assign match_o = match;
    assign flag_o  = flag;
    assign irq_o   = flag & irq_en_i;

    // R2
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rg_q.run && !cnt_wr_i) |=> $stable(count_o));

    // R3
    match_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !per_wr_i && !cnt_wr_i && (rg_q.period != '0)) |=> !match_o);

endmodule

// File: tb/pmt_timer_tb.sv
`timescale 1ns/1ps
module pmt_timer_tb;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ctl_wr_i = 1'b0;
    logic [6:0] ctl_wdata_i = '0;
    logic       per_wr_i = 1'b0;
    logic [7:0] per_wdata_i = '0;
    logic       cnt_wr_i = 1'b0;
    logic [7:0] cnt_wdata_i = '0;
    logic       flag_clr_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic [7:0] count_o;
    logic       match_o;
    logic       flag_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk_i = ~clk_i;

    pmt_timer u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_wr_i    (ctl_wr_i),
        .ctl_wdata_i (ctl_wdata_i),
        .per_wr_i    (per_wr_i),
        .per_wdata_i (per_wdata_i),
        .cnt_wr_i    (cnt_wr_i),
        .cnt_wdata_i (cnt_wdata_i),
        .flag_clr_i  (flag_clr_i),
        .irq_en_i    (irq_en_i),
        .count_o     (count_o),
        .match_o     (match_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic wr_ctl(logic [3:0] post, logic run, logic [1:0] pre);
        ctl_wdata_i = {post, run, pre};
        ctl_wr_i = 1'b1;
        step();
        ctl_wr_i = 1'b0;
    endtask

    task automatic wr_per(logic [7:0] v);
        per_wdata_i = v;
        per_wr_i = 1'b1;
        step();
        per_wr_i = 1'b0;
    endtask

    task automatic wr_cnt(logic [7:0] v);
        cnt_wdata_i = v;
        cnt_wr_i = 1'b1;
        step();
        cnt_wr_i = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr_i = 1'b1;
        step();
        flag_clr_i = 1'b0;
    endtask

    task automatic prep(logic [7:0] period);
        wr_ctl(4'd0, 1'b0, 2'd0);
        wr_cnt(8'd0);
        wr_per(period);
        clr_flag();
    endtask

    task automatic t_reset();
        irq_en_i = 1'b1;
        #1;
        check("R1 count", int'(count_o), 0);
        check("R1 match", int'(match_o), 0);
        check("R1 flag", int'(flag_o), 0);
        check("R1 irq", int'(irq_o), 0);
        irq_en_i = 1'b0;
    endtask

    task automatic t_wrap();
        prep(8'd3);
        wr_ctl(4'd0, 1'b1, 2'd0);
        for (int i = 1; i <= 12; i++) begin
            step();
            check("R3 count", int'(count_o), i % 4);
            check("R3 match", int'(match_o), (i % 4 == 0) ? 1 : 0);
        end
        prep(8'd0);
        wr_ctl(4'd0, 1'b1, 2'd1);
        for (int i = 1; i <= 9; i++) begin
            step();
            check("R3 zero period count", int'(count_o), 0);
            check("R3 zero period match", int'(match_o), (i % 4 == 0) ? 1 : 0);
        end
    endtask

    task automatic t_prescale();
        prep(8'd1);
        wr_ctl(4'd0, 1'b1, 2'd1);
        for (int i = 1; i <= 12; i++) begin
            step();
            check("R4 div4", int'(count_o), (i / 4) % 2);
        end
        prep(8'd1);
        wr_ctl(4'd0, 1'b1, 2'd2);
        for (int i = 1; i <= 33; i++) begin
            step();
            if (i == 15 || i == 16 || i == 31 || i == 32)
                check("R4 div16", int'(count_o), (i / 16) % 2);
        end
        prep(8'd1);
        wr_ctl(4'd0, 1'b1, 2'd3);
        for (int i = 1; i <= 16; i++) begin
            step();
            if (i >= 15) check("R4 div16 alt", int'(count_o), (i / 16) % 2);
        end
    endtask

    task automatic t_hold();
        int held;
        prep(8'd9);
        wr_ctl(4'd0, 1'b1, 2'd0);
        step();
        step();
        wr_ctl(4'd0, 1'b0, 2'd0);
        held = int'(count_o);
        check("R2 advanced", held, 3);
        for (int i = 0; i < 5; i++) begin
            step();
            check("R2 hold", int'(count_o), held);
        end
    endtask

    task automatic t_postscale();
        prep(8'd1);
        wr_ctl(4'd2, 1'b1, 2'd0);
        for (int i = 1; i <= 7; i++) begin
            step();
            if (i == 6) check("R5 ratio3 early", int'(flag_o), 0);
            if (i == 7) check("R5 ratio3 set", int'(flag_o), 1);
        end
        prep(8'd1);
        wr_ctl(4'd15, 1'b1, 2'd0);
        for (int i = 1; i <= 33; i++) begin
            step();
            if (i == 32) check("R5 ratio16 early", int'(flag_o), 0);
            if (i == 33) check("R5 ratio16 set", int'(flag_o), 1);
        end
        irq_en_i = 1'b0;
        #1;
        check("R8 masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        #1;
        check("R8 enabled", int'(irq_o), 1);
        wr_ctl(4'd15, 1'b0, 2'd0);
        for (int i = 0; i < 5; i++) begin
            step();
            check("R6 sticky", int'(flag_o), 1);
        end
        clr_flag();
        check("R6 cleared", int'(flag_o), 0);
        check("R8 follows flag", int'(irq_o), 0);
        irq_en_i = 1'b0;
    endtask

    task automatic t_set_vs_clear();
        prep(8'd1);
        wr_ctl(4'd0, 1'b1, 2'd0);
        step();
        step();
        check("R7 match seen", int'(match_o), 1);
        flag_clr_i = 1'b1;
        step();
        flag_clr_i = 1'b0;
        check("R7 set wins", int'(flag_o), 1);
        flag_clr_i = 1'b1;
        step();
        flag_clr_i = 1'b0;
        check("R6 plain clear", int'(flag_o), 0);
        step();
        check("R5 ratio1 set", int'(flag_o), 1);
    endtask

    task automatic t_post_reset(bit use_period);
        prep(8'd1);
        wr_ctl(4'd3, 1'b1, 2'd0);
        for (int i = 1; i <= 7; i++) step();
        if (use_period) wr_per(8'd1);
        else wr_ctl(4'd3, 1'b1, 2'd0);
        check("R9 count kept", int'(count_o), 0);
        for (int i = 9; i <= 15; i++) begin
            step();
            if (i == 9 || i == 14) check("R9 group restarted", int'(flag_o), 0);
            if (i == 15) check("R9 group complete", int'(flag_o), 1);
        end
    endtask

    task automatic t_load();
        prep(8'd9);
        wr_cnt(8'd5);
        check("R10 load", int'(count_o), 5);
        wr_ctl(4'd0, 1'b1, 2'd0);
        step();
        check("R10 continue", int'(count_o), 6);
        prep(8'd9);
        wr_ctl(4'd0, 1'b1, 2'd1);
        step();
        step();
        wr_cnt(8'd7);
        check("R10 load mid", int'(count_o), 7);
        for (int i = 0; i < 3; i++) step();
        check("R10 prescale restart", int'(count_o), 7);
        step();
        check("R10 next tick", int'(count_o), 8);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        step();
        t_wrap();
        t_prescale();
        t_hold();
        t_postscale();
        t_set_vs_clear();
        t_post_reset(1'b0);
        t_post_reset(1'b1);
        t_load();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule